// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Execution Unit

This unit is the arithmetic stage of a 64-bit register virtual machine used for packet filtering. It takes one arithmetic instruction, already split into its 8-bit opcode, 16-bit offset field and 32-bit immediate, together with the current destination and source register values. It returns the value to be written back and a write strobe. No clock is involved: the result settles within the same cycle as its inputs.

The opcode carries three fields. Bits [2:0] give the instruction class: 32-bit or 64-bit arithmetic. Bit 3 picks the second operand: the immediate or the source register. Bits [7:4] give the operation. The offset field further qualifies two operations. On divide and remainder it selects signed arithmetic. On move it selects a sign-extending copy of the low 8, 16 or 32 source bits. Any combination the unit cannot execute is flagged as illegal, and no write happens. Register storage, byte swapping and memory access belong to neighbouring blocks.

Top module: `pfvm_alu`

## Requirements
- R1: opcode[2:0] = 3'b100 selects 32-bit arithmetic and 3'b111 selects 64-bit arithmetic. Every other class value is illegal.
- R2: opcode[7:4] selects the operation: 0 add, 1 subtract, 2 multiply, 3 divide, 4 or, 5 and, 6 shift left, 7 logical shift right, 8 negate, 9 remainder, 10 xor, 11 move, 12 arithmetic shift right. Codes 13 to 15, which include byte swap, are illegal.
- R3: A 32-bit class operation works only on the low 32 bits of both operands. Its result is zero-extended to 64 bits.
- R4: opcode[3] = 0 takes the 32-bit immediate, sign-extended, as the source operand. opcode[3] = 1 takes the source register.
- R5: Divide by a zero source gives 0. Remainder by a zero source returns the destination, limited to the class width.
- R6: On divide and remainder, offset 0 means unsigned and offset 1 means signed. Signed division truncates toward zero. The remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value, with remainder 0.
- R7: Add, subtract, multiply, negate, or, and, xor and plain move (offset 0) wrap modulo 2^32 or 2^64 with no other effect.
- R8: Shift amounts are the source ANDed with 0x3F in the 64-bit class and with 0x1F in the 32-bit class. The arithmetic right shift fills with the destination's sign bit.
- R9: A move with offset 8, 16 or 32 sign-extends the low 8, 16 or 32 source bits. Offset 32 is allowed only in the 64-bit class.
- R10: An illegal instruction has one of: a bad class, a code of 13 or more, or an offset outside the values allowed for its code (0 for every code; also 1 for divide and remainder; also 8, 16 and 32 for move). It raises `illegal`, drops `wr_en` and drives `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 8 | Operation [7:4], source select [3], class [2:0] |
| offset | input | 16 | Signedness selector for divide/remainder, extension width for move |
| imm | input | 32 | Immediate operand, sign-extended when used |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| result | output | 64 | Value to write back, 0 when illegal |
| wr_en | output | 1 | Write-back strobe, high for a legal instruction |
| illegal | output | 1 | Instruction cannot be executed |

## Verification
The zero-divisor rule and the signed selection by offset meet when a signed divide or remainder gets a zero source. The zero rule must still win, and the dividend's sign must not leak into the result. The bench also drives the most negative dividend with a -1 divisor, where signed quotient overflow and the signedness selection occur together. It drives the 32-bit class with a zero remainder divisor and a destination whose upper half is set, so the returned destination must also be truncated. Each result is compared against values worked out by hand from the requirements.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

  localparam int unsigned REG_W      = 64;
  localparam int unsigned IMM_W      = 32;
  localparam int unsigned OFF_W      = 16;
  localparam int unsigned OPC_W      = 8;
  localparam int unsigned LANE_COUNT = 2;   // wide lane, then half lane

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_REM  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_SAR  = 4'hC,
    OP_SWAP = 4'hD,
    OP_RSVE = 4'hE,
    OP_RSVF = 4'hF
  } alu_op_e;

  // offset values that qualify an operation
  function automatic logic off_allowed(input alu_op_e op, input logic [15:0] off,
                                       input logic wide);
    case (op)
      OP_DIV, OP_REM: off_allowed = (off == 16'd0) || (off == 16'd1);
      OP_MOV:         off_allowed = (off == 16'd0) || (off == 16'd8) ||
                                    (off == 16'd16) || (wide && off == 16'd32);
      OP_SWAP, OP_RSVE, OP_RSVF: off_allowed = 1'b0;
      default:        off_allowed = (off == 16'd0);
    endcase
  endfunction

endpackage

// File: rtl/pfvm_alu_decode.sv
module pfvm_alu_decode
  import pfvm_alu_pkg::*;
#(
  parameter int unsigned OPC_BITS = OPC_W,
  parameter int unsigned OFF_BITS = OFF_W
) (
  input  logic [OPC_BITS-1:0] opcode,
  input  logic [OFF_BITS-1:0] offset,
  output alu_op_e             op,
  output logic                wide,
  output logic                use_reg,
  output logic                signed_sel,
  output logic [5:0]          sx_bits,
  output logic                illegal
);

  logic [2:0] cls;
  logic       cls_ok;
  logic       off_ok;

  always_comb begin
    cls        = opcode[2:0];
    op         = alu_op_e'(opcode[7:4]);
    use_reg    = opcode[3];
    wide       = (cls == CLS_WIDE);
    cls_ok     = (cls == CLS_WIDE) || (cls == CLS_NARROW);
    off_ok     = off_allowed(op, 16'(offset), wide);
    signed_sel = offset[0];
    sx_bits    = offset[5:0];
    illegal    = !(cls_ok && off_ok);
  end

endmodule

// File: rtl/pfvm_alu_operand.sv
module pfvm_alu_operand
  import pfvm_alu_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned IMM_BITS = IMM_W
) (
  input  logic                use_reg,
  input  logic [IMM_BITS-1:0] imm,
  input  logic [DATA_W-1:0]   src_val,
  output logic [DATA_W-1:0]   operand
);

  localparam int unsigned PAD_W = DATA_W - IMM_BITS;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    imm_ext = {{PAD_W{imm[IMM_BITS-1]}}, imm};
    operand = use_reg ? src_val : imm_ext;
  end

endmodule

// File: rtl/pfvm_alu_lane.sv
module pfvm_alu_lane
  import pfvm_alu_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  alu_op_e      op,
  input  logic         signed_sel,
  input  logic [5:0]   sx_bits,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zero_div
);

  localparam int unsigned SH_W = $clog2(W);

  function automatic logic [W-1:0] neg_f(input logic [W-1:0] v);
    return W'(0) - v;
  endfunction

  function automatic logic [W-1:0] mag_f(input logic [W-1:0] v);
    return v[W-1] ? neg_f(v) : v;
  endfunction

  function automatic logic [W-1:0] sdiv_f(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] q;
    q = mag_f(x) / mag_f(y);
    return (x[W-1] ^ y[W-1]) ? neg_f(q) : q;
  endfunction

  function automatic logic [W-1:0] srem_f(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    r = mag_f(x) % mag_f(y);
    return x[W-1] ? neg_f(r) : r;
  endfunction

  function automatic logic [W-1:0] sext_f(input logic [W-1:0] v, input int unsigned n);
    logic [W-1:0] keep;
    keep = (W'(1) << n) - W'(1);
    return (v & keep) | ({W{v[n-1]}} & ~keep);
  endfunction

  logic [W-1:0]    b_safe;
  logic [SH_W-1:0] amt;

  always_comb begin
    zero_div = (b == '0);
    b_safe   = zero_div ? W'(1) : b;
    amt      = b[SH_W-1:0];
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = zero_div ? '0 : (signed_sel ? sdiv_f(a, b_safe) : a / b_safe);
      OP_REM:  res = zero_div ? a  : (signed_sel ? srem_f(a, b_safe) : a % b_safe);
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_SHL:  res = a << amt;
      OP_SHR:  res = a >> amt;
      OP_SAR:  res = W'($signed(a) >>> amt);
      OP_NEG:  res = neg_f(a);
      OP_MOV:  res = (sx_bits == 6'd0) ? b : sext_f(b, int'(sx_bits));
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
  import pfvm_alu_pkg::*;
(
  input  logic [7:0]  opcode,
  input  logic [15:0] offset,
  input  logic [31:0] imm,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  output logic [63:0] result,
  output logic        wr_en,
  output logic        illegal
);

  alu_op_e          op;
  logic             is_wide;
  logic             use_reg;
  logic             signed_sel;
  logic [5:0]       sx_bits;
  logic [REG_W-1:0] operand;

  // named events for the checker
  logic             op_is_div;
  logic             op_is_mod;
  logic             div_zero;

  logic [REG_W-1:0] lane_res  [LANE_COUNT];
  logic             lane_zero [LANE_COUNT];

  pfvm_alu_decode u_dec (
    .opcode     (opcode),
    .offset     (offset),
    .op         (op),
    .wide       (is_wide),
    .use_reg    (use_reg),
    .signed_sel (signed_sel),
    .sx_bits    (sx_bits),
    .illegal    (illegal)
  );

  pfvm_alu_operand u_opnd (
    .use_reg (use_reg),
    .imm     (imm),
    .src_val (src_val),
    .operand (operand)
  );

  for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
    localparam int unsigned LW = REG_W >> g;
    logic [LW-1:0] lres;
    logic          lzero;

    pfvm_alu_lane #(.W(LW)) u_lane (
      .op         (op),
      .signed_sel (signed_sel),
      .sx_bits    (sx_bits),
      .a          (dst_val[LW-1:0]),
      .b          (operand[LW-1:0]),
      .res        (lres),
      .zero_div   (lzero)
    );

    assign lane_res[g]  = REG_W'(lres);
    assign lane_zero[g] = lzero;
  end

  always_comb begin
    op_is_div = (op == OP_DIV);
    op_is_mod = (op == OP_REM);
    div_zero  = is_wide ? lane_zero[0] : lane_zero[1];
    wr_en     = !illegal;
    result    = illegal ? '0 : (is_wide ? lane_res[0] : lane_res[1]);
  end

endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk #(
  parameter int unsigned DW = 64
) (
  input logic [7:0]    opcode,
  input logic [DW-1:0] dst_val,
  input logic [DW-1:0] result,
  input logic          wr_en,
  input logic          illegal,
  input logic          is_wide,
  input logic          op_is_div,
  input logic          op_is_mod,
  input logic          div_zero
);

  localparam int unsigned HW = DW / 2;

  always_comb begin
    if (illegal) begin
      p_illegal_quiet_r10: assert (!wr_en && result == '0)
        else $error("illegal instruction wrote or produced data");
    end
    if (!(opcode[2:0] == 3'b100 || opcode[2:0] == 3'b111)) begin
      p_bad_class_r1: assert (illegal)
        else $error("non-arithmetic class accepted");
    end
    if (opcode[7:4] >= 4'hD) begin
      p_bad_code_r2: assert (illegal)
        else $error("unsupported operation code accepted");
    end
    if (wr_en && !is_wide) begin
      p_narrow_upper_zero_r3: assert (result[DW-1:HW] == '0)
        else $error("32-bit result has upper bits set");
    end
    if (wr_en && op_is_div && div_zero) begin
      p_div_zero_r5: assert (result == '0)
        else $error("divide by zero not zero");
    end
    if (wr_en && op_is_mod && div_zero) begin
      p_mod_zero_r5: assert (result == (is_wide ? dst_val : DW'(dst_val[HW-1:0])))
        else $error("remainder by zero altered destination");
    end
  end

endmodule

bind pfvm_alu pfvm_alu_chk #(.DW(64)) u_chk (
  .opcode    (opcode),
  .dst_val   (dst_val),
  .result    (result),
  .wr_en     (wr_en),
  .illegal   (illegal),
  .is_wide   (is_wide),
  .op_is_div (op_is_div),
  .op_is_mod (op_is_mod),
  .div_zero  (div_zero)
);

// File: tb/sim_pfvm_alu.sv
`timescale 1ns/1ps
module sim_pfvm_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [63:0] result;
  logic        wr_en;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        we;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  pfvm_alu u0 (
    .opcode  (opcode),
    .offset  (offset),
    .imm     (imm),
    .dst_val (dst_val),
    .src_val (src_val),
    .result  (result),
    .wr_en   (wr_en),
    .illegal (illegal)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: apply one instruction after a rising edge and queue its expectation
  task automatic run(input logic [7:0] o, input logic [15:0] f, input logic [31:0] i,
                     input logic [63:0] d, input logic [63:0] s,
                     input logic [63:0] er, input logic ew, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    opcode  = o;
    offset  = f;
    imm     = i;
    dst_val = d;
    src_val = s;
    e.res = er;
    e.we  = ew;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic bad(input logic [7:0] o, input logic [15:0] f, input string tag);
    run(o, f, 32'h0, 64'h1234, 64'h5678, 64'h0, 1'b0, tag);
  endtask

  // monitor: compare between edges
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res || wr_en !== e.we || illegal !== !e.we) begin
        errors++;
        $display("FAIL %s: result=%h wr_en=%b illegal=%b expected result=%h wr_en=%b illegal=%b",
                 e.tag, result, wr_en, illegal, e.res, e.we, !e.we);
      end
    end
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: class 0 -> illegal (R10)
    checks++;
    if (illegal !== 1'b1 || wr_en !== 1'b0 || result !== 64'h0) begin
      errors++;
      $display("FAIL R10 idle: result=%h wr_en=%b illegal=%b expected 0 0 1",
               result, wr_en, illegal);
    end

    // R2 R7 wrap, 64-bit class, register source
    run(8'h0F, 16'd0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 1'b1, "R7 add64 wrap");
    // R3 narrow add wraps in 32 bits and clears upper half
    run(8'h0C, 16'd0, 32'h0, 64'h0000_0001_FFFF_FFFF, 64'd1, 64'd0, 1'b1, "R3 add32 wrap");
    // R4 immediate sign-extended
    run(8'h17, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'hDEAD, 64'd6, 1'b1, "R4 sub64 imm -1");
    run(8'hB7, 16'd0, 32'h8000_0000, 64'd0, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b1, "R4 mov64 imm");
    run(8'hB4, 16'd0, 32'h8000_0000, 64'd0, 64'd0, 64'h0000_0000_8000_0000, 1'b1, "R3 mov32 imm");
    run(8'h24, 16'd0, 32'd3, 64'h0000_0001_8000_0000, 64'd0, 64'h0000_0000_8000_0000, 1'b1, "R3 mul32 imm");
    // R7 logic ops and negate
    run(8'h4F, 16'd0, 32'h0, 64'hF0, 64'h0F, 64'hFF, 1'b1, "R7 or64");
    run(8'h5F, 16'd0, 32'h0, 64'hFF0, 64'h0FF, 64'h0F0, 1'b1, "R7 and64");
    run(8'hAF, 16'd0, 32'h0, 64'hFF, 64'h0F, 64'hF0, 1'b1, "R7 xor64");
    run(8'h8F, 16'd0, 32'h0, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R7 neg64");
    run(8'h8C, 16'd0, 32'h0, 64'd1, 64'd0, 64'h0000_0000_FFFF_FFFF, 1'b1, "R7 neg32");
    // R2 unsigned divide / remainder
    run(8'h3F, 16'd0, 32'h0, 64'd100, 64'd7, 64'd14, 1'b1, "R2 div64");
    run(8'h9F, 16'd0, 32'h0, 64'd100, 64'd7, 64'd2, 1'b1, "R2 mod64");
    // R5 zero divisor
    run(8'h3F, 16'd0, 32'h0, 64'd100, 64'd0, 64'd0, 1'b1, "R5 div64 by 0");
    run(8'h9F, 16'd0, 32'h0, 64'd100, 64'd0, 64'd100, 1'b1, "R5 mod64 by 0");
    run(8'h9C, 16'd0, 32'h0, 64'hABCD_0000_0000_0055, 64'h7_0000_0000, 64'h55, 1'b1, "R5 mod32 by 0");
    // R6 signed variants, also combined with zero divisor
    run(8'h3F, 16'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFF2, 1'b1, "R6 sdiv64");
    run(8'h9F, 16'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, "R6 smod64");
    run(8'h3F, 16'd1, 32'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 1'b1, "R6 sdiv64 min/-1");
    run(8'h9F, 16'd1, 32'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'd0, 1'b1, "R6 smod64 min/-1");
    run(8'h3C, 16'd1, 32'h0, 64'h0000_0000_FFFF_FFF6, 64'd3, 64'h0000_0000_FFFF_FFFD, 1'b1, "R6 sdiv32");
    run(8'h3F, 16'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FF9C, 64'd0, 64'd0, 1'b1, "R6 R5 sdiv64 by 0");
    run(8'h9F, 16'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FF9C, 64'd0, 64'hFFFF_FFFF_FFFF_FF9C, 1'b1, "R6 R5 smod64 by 0");
    // R8 shifts
    run(8'h6F, 16'd0, 32'h0, 64'd1, 64'd65, 64'd2, 1'b1, "R8 shl64 masked");
    run(8'h6C, 16'd0, 32'h0, 64'd1, 64'd33, 64'd2, 1'b1, "R8 shl32 masked");
    run(8'h7F, 16'd0, 32'h0, 64'h8000_0000_0000_0000, 64'd63, 64'd1, 1'b1, "R8 shr64");
    run(8'hCF, 16'd0, 32'h0, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 1'b1, "R8 sar64");
    run(8'hCC, 16'd0, 32'h0, 64'h0000_0000_8000_0000, 64'd4, 64'h0000_0000_F800_0000, 1'b1, "R8 sar32");
    // R9 sign-extending moves
    run(8'hBF, 16'd8, 32'h0, 64'd0, 64'h80, 64'hFFFF_FFFF_FFFF_FF80, 1'b1, "R9 movsx8");
    run(8'hBF, 16'd16, 32'h0, 64'd0, 64'h1234_7FFF, 64'h7FFF, 1'b1, "R9 movsx16");
    run(8'hBF, 16'd32, 32'h0, 64'd0, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_8000_0001, 1'b1, "R9 movsx32");
    run(8'hBC, 16'd8, 32'h0, 64'd0, 64'hFF, 64'h0000_0000_FFFF_FFFF, 1'b1, "R9 movsx8 narrow");
    // R1 R2 R9 R10 illegal combinations
    bad(8'hBC, 16'd32, "R9 R10 movsx32 in narrow class");
    bad(8'hD4, 16'd0,  "R2 R10 byte swap code");
    bad(8'hFF, 16'd0,  "R2 R10 code 15");
    bad(8'h05, 16'd0,  "R1 R10 jump class");
    bad(8'h0D, 16'd0,  "R1 R10 class 5 with reg");
    bad(8'h0F, 16'd1,  "R10 add with offset 1");
    bad(8'h3F, 16'd2,  "R10 div offset 2");
    bad(8'hBF, 16'd4,  "R10 mov offset 4");
    // back to legal after illegal
    run(8'h07, 16'd0, 32'd10, 64'd5, 64'd0, 64'd15, 1'b1, "R1 R4 add64 imm");

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule